// File: doc/BRIEF.md
# Two-Axis Video Scan Sequencer

This block produces the handle positions of one regular two-dimensional scan. Each axis has its own stepper. The stepper walks a run of coordinates ("line") from a moving lower edge up to a moving upper edge, then shifts both edges by signed amounts. A two-bit coupling mode chooses how the two axes share time. They can move together on every output, or one axis can sweep a whole line while the other waits and then takes a single step.

A scan is set up in one cycle. Software-free logic upstream presents seven parameters per axis, a coupling mode, a context offset and a relative flag, and pulses `start`. The block then streams 32-bit handles (y in bits 31:16, x in bits 15:0) over a valid/ready handshake. It marks the final handle of the scan and goes idle once that handle is accepted. The context offset lets several data maps share one physical memory. The raw final position is kept so that a later scan can be placed relative to it.

Top module: `vscan_seq`

## Requirements
- R1: After reset, `pos_valid`, `pos_last` and `busy` are 0. A `start` pulse while idle captures all parameters, the mode, the context offset and the relative flag. The first handle is then valid in the next cycle, and later changes on the parameter inputs have no effect on that scan.
- R2: Within a line, an axis emits its line's lower edge first. It then adds its address step while the result does not exceed the line's upper edge (unsigned compare without wrap). The lower edge is always emitted, even when it lies above the upper edge.
- R3: After each line, the lower edge of an axis moves by its signed lower-edge step and the upper edge moves by its signed upper-edge step, both modulo 2^16. The next line starts at the new lower edge. A line is the axis's final line when its lower edge has reached its floor, or its upper edge has reached its ceiling. "Reached" means `>=` for a non-negative step (MSB 0) and `<=` for a negative step (MSB 1).
- R4: Mode 2'b00 (lock-step) advances both axes on every accepted handle. Mode 2'b11 behaves exactly as 2'b00.
- R5: Mode 2'b01 advances x on every accepted handle and advances y only on the handle where x ends a line.
- R6: Mode 2'b10 advances y on every accepted handle and advances x only on the handle where y ends a line.
- R7: A handle is flagged with `pos_last` when accepting it would advance an axis past the end of that axis's final line. After it is accepted, `pos_valid` and `busy` drop in the next cycle. Any other accepted handle is followed by another valid handle.
- R8: `pos_handle` holds {y + offset[31:16], x + offset[15:0]}, each half added modulo 2^16.
- R9: While `pos_valid` is 1 and `pos_ready` is 0, the handle, the last flag and all stepper state hold.
- R10: The raw position (without context offset) of the final handle is saved. After reset the saved position is (0,0). A scan launched with `rel_origin`=1 adds the saved x to the x floor, initial lower edge, ceiling and initial upper edge, and adds the saved y to the same four y values.
- R11: A `start` pulse while `busy` is 1 is ignored, and the scan in progress continues unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Launch a scan when idle |
| rel_origin | input | 1 | Place the scan relative to the saved final position |
| couple_mode | input | 2 | Axis coupling: 00/11 lock-step, 01 y waits for x, 10 x waits for y |
| ctx_offset | input | 32 | Context offset, y in 31:16, x in 15:0 |
| x_floor | input | 16 | x bound for the lower edge |
| x_base_init | input | 16 | x initial lower edge |
| x_base_step | input | 16 | x signed lower-edge step per line |
| x_ceil | input | 16 | x bound for the upper edge |
| x_limit_init | input | 16 | x initial upper edge |
| x_limit_step | input | 16 | x signed upper-edge step per line |
| x_addr_step | input | 16 | x step within a line |
| y_floor | input | 16 | y bound for the lower edge |
| y_base_init | input | 16 | y initial lower edge |
| y_base_step | input | 16 | y signed lower-edge step per line |
| y_ceil | input | 16 | y bound for the upper edge |
| y_limit_init | input | 16 | y initial upper edge |
| y_limit_step | input | 16 | y signed upper-edge step per line |
| y_addr_step | input | 16 | y step within a line |
| pos_ready | input | 1 | Downstream accepts the handle |
| pos_valid | output | 1 | A handle is presented |
| pos_handle | output | 32 | Offset handle, y in 31:16, x in 15:0 |
| pos_last | output | 1 | The presented handle is the final one |
| busy | output | 1 | A scan is in progress |

## Verification
The assertions check the handshake rules on every cycle. A stalled handle and its last flag must hold, a launch from idle must present a handle in the next cycle, and an accepted handle must either end the scan or be followed by another. The bench scenarios are the only way to show the actual coordinate order. That covers the line walk, edge stepping with positive and negative steps, floor and ceiling termination, the three coupling modes and the alias mode, the context offset, relative placement and the ignored relaunch.

// File: rtl/vscan_pkg.sv
package vscan_pkg;

    localparam int COORD_W  = 16;
    localparam int NUM_AXES = 2;
    localparam int HANDLE_W = NUM_AXES * COORD_W;

    typedef logic [COORD_W-1:0] coord_t;

    typedef enum logic [1:0] {
        CPL_LOCK      = 2'b00,
        CPL_Y_AFTER_X = 2'b01,
        CPL_X_AFTER_Y = 2'b10,
        CPL_LOCK_ALT  = 2'b11
    } couple_e;

    typedef struct packed {
        coord_t floor_pos;
        coord_t base_init;
        coord_t base_step;
        coord_t ceil_pos;
        coord_t limit_init;
        coord_t limit_step;
        coord_t addr_step;
    } axis_cfg_t;

    typedef struct packed {
        logic line_end;
        logic scan_end;
    } axis_flags_t;

    // An edge has reached its bound, in the direction its step moves it.
    function automatic logic edge_reached(coord_t pos, coord_t bound, coord_t step);
        return step[COORD_W-1] ? (pos <= bound) : (pos >= bound);
    endfunction

endpackage

// File: rtl/vscan_axis.sv
module vscan_axis
    import vscan_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        load,
    input  axis_cfg_t   cfg_in,
    input  logic        advance,
    output coord_t      addr,
    output axis_flags_t flags
);

    axis_cfg_t        cfg_q;
    coord_t           base_q;
    coord_t           limit_q;
    coord_t           addr_q;
    logic [COORD_W:0] addr_next_wide;
    coord_t           base_next;
    logic             final_line;

    assign addr_next_wide = {1'b0, addr_q} + {1'b0, cfg_q.addr_step};
    assign base_next      = base_q + cfg_q.base_step;
    assign final_line     = edge_reached(base_q, cfg_q.floor_pos, cfg_q.base_step)
                          | edge_reached(limit_q, cfg_q.ceil_pos, cfg_q.limit_step);

    assign flags.line_end = addr_next_wide > {1'b0, limit_q};
    assign flags.scan_end = flags.line_end & final_line;
    assign addr           = addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q   <= '0;
            base_q  <= '0;
            limit_q <= '0;
            addr_q  <= '0;
        end else if (load) begin
            cfg_q   <= cfg_in;
            base_q  <= cfg_in.base_init;
            limit_q <= cfg_in.limit_init;
            addr_q  <= cfg_in.base_init;
        end else if (advance) begin
            if (flags.line_end) begin
                base_q  <= base_next;
                limit_q <= limit_q + cfg_q.limit_step;
                addr_q  <= base_next;
            end else begin
                addr_q  <= addr_next_wide[COORD_W-1:0];
            end
        end
    end

endmodule

// File: rtl/vscan_couple.sv
module vscan_couple
    import vscan_pkg::*;
(
    input  couple_e     mode,
    input  axis_flags_t fx,
    input  axis_flags_t fy,
    input  logic        fire,
    output logic        adv_x,
    output logic        adv_y,
    output logic        last
);

    always_comb begin
        unique case (mode)
            CPL_Y_AFTER_X: begin
                adv_x = fire;
                adv_y = fire & fx.line_end;
                last  = fx.scan_end | (fx.line_end & fy.scan_end);
            end
            CPL_X_AFTER_Y: begin
                adv_x = fire & fy.line_end;
                adv_y = fire;
                last  = fy.scan_end | (fy.line_end & fx.scan_end);
            end
            default: begin
                adv_x = fire;
                adv_y = fire;
                last  = fx.scan_end | fy.scan_end;
            end
        endcase
    end

endmodule

// File: rtl/vscan_seq.sv
module vscan_seq
    import vscan_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                start,
    input  logic                rel_origin,
    input  logic [1:0]          couple_mode,
    input  logic [HANDLE_W-1:0] ctx_offset,
    input  logic [COORD_W-1:0]  x_floor,
    input  logic [COORD_W-1:0]  x_base_init,
    input  logic [COORD_W-1:0]  x_base_step,
    input  logic [COORD_W-1:0]  x_ceil,
    input  logic [COORD_W-1:0]  x_limit_init,
    input  logic [COORD_W-1:0]  x_limit_step,
    input  logic [COORD_W-1:0]  x_addr_step,
    input  logic [COORD_W-1:0]  y_floor,
    input  logic [COORD_W-1:0]  y_base_init,
    input  logic [COORD_W-1:0]  y_base_step,
    input  logic [COORD_W-1:0]  y_ceil,
    input  logic [COORD_W-1:0]  y_limit_init,
    input  logic [COORD_W-1:0]  y_limit_step,
    input  logic [COORD_W-1:0]  y_addr_step,
    input  logic                pos_ready,
    output logic                pos_valid,
    output logic [HANDLE_W-1:0] pos_handle,
    output logic                pos_last,
    output logic                busy
);

    logic                  busy_q;
    couple_e               mode_q;
    coord_t [NUM_AXES-1:0] ctx_q;
    coord_t [NUM_AXES-1:0] origin_q;

    axis_cfg_t             cfg_raw [NUM_AXES];
    axis_cfg_t             cfg_adj [NUM_AXES];
    coord_t                pos     [NUM_AXES];
    axis_flags_t           flg     [NUM_AXES];
    logic [NUM_AXES-1:0]   adv;
    logic                  launch;
    logic                  fire;
    logic                  last_raw;

    assign launch = start & ~busy_q;
    assign fire   = busy_q & pos_ready;

    assign cfg_raw[0] = '{floor_pos: x_floor, base_init: x_base_init, base_step: x_base_step,
                          ceil_pos: x_ceil, limit_init: x_limit_init, limit_step: x_limit_step,
                          addr_step: x_addr_step};
    assign cfg_raw[1] = '{floor_pos: y_floor, base_init: y_base_init, base_step: y_base_step,
                          ceil_pos: y_ceil, limit_init: y_limit_init, limit_step: y_limit_step,
                          addr_step: y_addr_step};

    for (genvar a = 0; a < NUM_AXES; a++) begin : g_axis
        coord_t shift;
        assign shift = rel_origin ? origin_q[a] : '0;
        assign cfg_adj[a] = '{floor_pos:  cfg_raw[a].floor_pos + shift,
                              base_init:  cfg_raw[a].base_init + shift,
                              base_step:  cfg_raw[a].base_step,
                              ceil_pos:   cfg_raw[a].ceil_pos + shift,
                              limit_init: cfg_raw[a].limit_init + shift,
                              limit_step: cfg_raw[a].limit_step,
                              addr_step:  cfg_raw[a].addr_step};

        vscan_axis u_axis (
            .clk     (clk),
            .rst     (rst),
            .load    (launch),
            .cfg_in  (cfg_adj[a]),
            .advance (adv[a]),
            .addr    (pos[a]),
            .flags   (flg[a])
        );
    end

    vscan_couple u_couple (
        .mode  (mode_q),
        .fx    (flg[0]),
        .fy    (flg[1]),
        .fire  (fire),
        .adv_x (adv[0]),
        .adv_y (adv[1]),
        .last  (last_raw)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            mode_q   <= CPL_LOCK;
            ctx_q    <= '0;
            origin_q <= '0;
        end else if (launch) begin
            busy_q   <= 1'b1;
            mode_q   <= couple_e'(couple_mode);
            ctx_q    <= ctx_offset;
        end else if (fire && last_raw) begin
            busy_q      <= 1'b0;
            origin_q[0] <= pos[0];
            origin_q[1] <= pos[1];
        end
    end

    assign pos_valid  = busy_q;
    assign busy       = busy_q;
    assign pos_last   = busy_q & last_raw;
    assign pos_handle = {pos[1] + ctx_q[1], pos[0] + ctx_q[0]};

endmodule

// File: rtl/vscan_seq_chk.sv
module vscan_seq_chk
    import vscan_pkg::*;
(
    input logic                clk,
    input logic                rst,
    input logic                start,
    input logic                pos_ready,
    input logic                pos_valid,
    input logic                pos_last,
    input logic                busy,
    input logic [HANDLE_W-1:0] pos_handle
);

    // R9
    stall_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (pos_valid && !pos_ready) |=> (pos_valid && $stable(pos_handle) && $stable(pos_last)));

    // R7
    scan_end_chk: assert property (@(posedge clk) disable iff (rst)
        (pos_valid && pos_ready && pos_last) |=> (!pos_valid && !busy));

    // R7
    scan_cont_chk: assert property (@(posedge clk) disable iff (rst)
        (pos_valid && pos_ready && !pos_last) |=> pos_valid);

    // R1
    launch_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (pos_valid && busy));

    // R7
    last_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(pos_last) |-> pos_valid);

endmodule

bind vscan_seq vscan_seq_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .start      (start),
    .pos_ready  (pos_ready),
    .pos_valid  (pos_valid),
    .pos_last   (pos_last),
    .busy       (busy),
    .pos_handle (pos_handle)
);

// File: tb/sim_vscan_seq.sv
`timescale 1ns/1ps
module sim_vscan_seq;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        rel_origin = 1'b0;
    logic [1:0]  couple_mode = 2'b00;
    logic [31:0] ctx_offset = '0;
    logic [15:0] x_floor = '0, x_base_init = '0, x_base_step = '0, x_ceil = '0;
    logic [15:0] x_limit_init = '0, x_limit_step = '0, x_addr_step = '0;
    logic [15:0] y_floor = '0, y_base_init = '0, y_base_step = '0, y_ceil = '0;
    logic [15:0] y_limit_init = '0, y_limit_step = '0, y_addr_step = '0;
    logic        pos_ready = 1'b1;
    logic        pos_valid;
    logic [31:0] pos_handle;
    logic        pos_last;
    logic        busy;

    int errors = 0;
    int checks = 0;
    logic [31:0] exp_h [0:15];

    always #2.5 clk = ~clk;

    vscan_seq u0 (
        .clk(clk), .rst(rst), .start(start), .rel_origin(rel_origin),
        .couple_mode(couple_mode), .ctx_offset(ctx_offset),
        .x_floor(x_floor), .x_base_init(x_base_init), .x_base_step(x_base_step),
        .x_ceil(x_ceil), .x_limit_init(x_limit_init), .x_limit_step(x_limit_step),
        .x_addr_step(x_addr_step),
        .y_floor(y_floor), .y_base_init(y_base_init), .y_base_step(y_base_step),
        .y_ceil(y_ceil), .y_limit_init(y_limit_init), .y_limit_step(y_limit_step),
        .y_addr_step(y_addr_step),
        .pos_ready(pos_ready), .pos_valid(pos_valid), .pos_handle(pos_handle),
        .pos_last(pos_last), .busy(busy)
    );

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, expv);
        end
    endtask

    task automatic set_x(input logic [15:0] f, b0, db, c, l0, dl, da);
        x_floor = f; x_base_init = b0; x_base_step = db;
        x_ceil = c; x_limit_init = l0; x_limit_step = dl; x_addr_step = da;
    endtask

    task automatic set_y(input logic [15:0] f, b0, db, c, l0, dl, da);
        y_floor = f; y_base_init = b0; y_base_step = db;
        y_ceil = c; y_limit_init = l0; y_limit_step = dl; y_addr_step = da;
    endtask

    // Pulse start for one edge; returns at the falling edge where the first handle is shown.
    task automatic launch();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic collect(input string tag, input int n, input int stall_at, input bit poke);
        for (int i = 0; i < n; i++) begin
            check(pos_valid === 1'b1, {tag, " valid"}, {31'd0, pos_valid}, 32'd1);
            check(pos_handle === exp_h[i], {tag, " handle"}, pos_handle, exp_h[i]);
            check(pos_last === (i == n - 1), {tag, " last flag (R7)"}, {31'd0, pos_last},
                  {31'd0, (i == n - 1)});
            if (i == stall_at) begin
                pos_ready = 1'b0;
                for (int k = 0; k < 3; k++) begin
                    @(negedge clk);
                    check(pos_valid === 1'b1 && pos_handle === exp_h[i],
                          {tag, " stall hold R9"}, pos_handle, exp_h[i]);
                end
                pos_ready = 1'b1;
            end
            if (poke && i == 1) begin
                start = 1'b1;
                x_base_init = 16'h7777;
                y_base_init = 16'h7777;
            end
            @(negedge clk);
            start = 1'b0;
        end
        check(pos_valid === 1'b0 && busy === 1'b0, {tag, " idle after last R7"},
              {30'd0, pos_valid, busy}, 32'd0);
    endtask

    task automatic t_reset();
        check(pos_valid === 1'b0 && busy === 1'b0 && pos_last === 1'b0, "R1 reset idle",
              {29'd0, pos_valid, busy, pos_last}, 32'd0);
    endtask

    // R4 lock-step, R2 line walk, R9 stall
    task automatic t_lock(input logic [1:0] m, input bit poke, input string tag);
        couple_mode = m; ctx_offset = '0; rel_origin = 1'b0;
        set_x(16'd0, 16'd0, 16'd0, 16'd100, 16'd3, 16'd0, 16'd1);
        set_y(16'd0, 16'd10, 16'd0, 16'd100, 16'd20, 16'd0, 16'd5);
        exp_h[0] = 32'h000A_0000;
        exp_h[1] = 32'h000F_0001;
        exp_h[2] = 32'h0014_0002;
        launch();
        collect(tag, 3, poke ? -1 : 1, poke);
    endtask

    // R5 y waits for x, R8 context offset
    task automatic t_y_after_x();
        couple_mode = 2'b01; ctx_offset = 32'h0100_0030; rel_origin = 1'b0;
        set_x(16'd100, 16'd0, 16'd0, 16'd100, 16'd2, 16'd0, 16'd1);
        set_y(16'd0, 16'd0, 16'd0, 16'd100, 16'd4, 16'd0, 16'd2);
        for (int yi = 0; yi < 3; yi++)
            for (int xi = 0; xi < 3; xi++)
                exp_h[yi*3 + xi] = {16'(16'h0100 + 2*yi), 16'(16'h0030 + xi)};
        launch();
        collect("R5 R8 y-after-x", 9, -1, 1'b0);
    endtask

    // R6 x waits for y, R3 edges moving to floor
    task automatic t_x_after_y();
        couple_mode = 2'b10; ctx_offset = 32'h0002_0001; rel_origin = 1'b0;
        set_x(16'd9, 16'd7, 16'd1, 16'd100, 16'd7, 16'd1, 16'd1);
        set_y(16'd100, 16'd5, 16'd0, 16'd100, 16'd6, 16'd0, 16'd1);
        exp_h[0] = 32'h0007_0008; exp_h[1] = 32'h0008_0008;
        exp_h[2] = 32'h0007_0009; exp_h[3] = 32'h0008_0009;
        exp_h[4] = 32'h0007_000A; exp_h[5] = 32'h0008_000A;
        launch();
        collect("R6 R3 x-after-y", 6, -1, 1'b0);
    endtask

    // R10 relative placement from the previous final position (9,6)
    task automatic t_relative();
        couple_mode = 2'b00; ctx_offset = '0; rel_origin = 1'b1;
        set_x(16'd0, 16'd1, 16'd0, 16'd100, 16'd2, 16'd0, 16'd1);
        set_y(16'd0, 16'd0, 16'd0, 16'd100, 16'd1, 16'd0, 16'd1);
        exp_h[0] = 32'h0006_000A;
        exp_h[1] = 32'h0007_000B;
        launch();
        rel_origin = 1'b0;
        collect("R10 relative", 2, -1, 1'b0);
    endtask

    // R3 ceiling termination with growing upper edge
    task automatic t_ceiling();
        couple_mode = 2'b01; ctx_offset = '0; rel_origin = 1'b0;
        set_x(16'd100, 16'd0, 16'd0, 16'd3, 16'd1, 16'd1, 16'd1);
        set_y(16'd100, 16'd0, 16'd0, 16'd100, 16'd0, 16'd0, 16'd1);
        exp_h[0] = 32'd0; exp_h[1] = 32'd1;
        exp_h[2] = 32'd0; exp_h[3] = 32'd1; exp_h[4] = 32'd2;
        exp_h[5] = 32'd0; exp_h[6] = 32'd1; exp_h[7] = 32'd2; exp_h[8] = 32'd3;
        launch();
        collect("R3 ceiling", 9, -1, 1'b0);
    endtask

    // R3 negative lower-edge step reaching the floor from above
    task automatic t_negative();
        couple_mode = 2'b01; ctx_offset = '0; rel_origin = 1'b0;
        set_x(16'd2, 16'd4, 16'hFFFF, 16'd100, 16'd4, 16'd0, 16'd1);
        set_y(16'd100, 16'd0, 16'd0, 16'd100, 16'd0, 16'd0, 16'd1);
        exp_h[0] = 32'd4; exp_h[1] = 32'd3; exp_h[2] = 32'd4;
        exp_h[3] = 32'd2; exp_h[4] = 32'd3; exp_h[5] = 32'd4;
        launch();
        collect("R3 negative step", 6, -1, 1'b0);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_lock(2'b00, 1'b0, "R4 R2 lock-step");
        t_y_after_x();
        t_x_after_y();
        t_relative();
        t_lock(2'b11, 1'b1, "R4 R11 R1 alias mode with ignored restart");
        t_ceiling();
        t_negative();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule